// File: doc/BRIEF.md
# Microcoded Memory Timing Sequencer

This block produces the control waveforms for an external memory from a user-loaded microcode table instead of fixed logic. A 64-entry table of 32-bit words holds the patterns. When an access request arrives, the request kind selects where in the table the pattern starts. On every clock, one word is latched and its fields drive the chip-select, byte-select and general-purpose control lines. The table index then moves forward until the block issues a word that carries the end-of-pattern bit.

A word can also carry a wait-enable bit. While such a word is current and the external wait input is asserted, the sequencer holds that word and does not advance. The wait input reaches the sequencer through a two-stage synchronizer. A host loads the table through a simple write port, but only while no pattern is running.

Microcode word layout (bit positions are part of the contract):

- [31:24] chip-select assert mask. A 1 drives the matching `cs_n` line low.
- [23:16] byte-select assert mask. A 1 drives the matching `bs_n` line low.
- [15:2] general-purpose line levels, copied to `gp`.
- [1] wait-enable.
- [0] end-of-pattern.

Top module: `mem_wave_seq`

## Requirements
- R1: During and right after reset, `busy` and `host_rej` are 0, `cs_n` and `bs_n` are all ones, and `gp` is zero.
- R2: A request accepted with `req_kind` 00, 01, 10 or 11 starts at table index 0x00, 0x08, 0x18 or 0x20 respectively.
- R3: A request is accepted on a clock edge where `busy` is 0, `req_valid` is 1 and `op_mode` is 00. From the next cycle, the outputs show the start word. Each later cycle without a freeze shows the next word.
- R4: The cycle that shows a word with bit 0 set is the last busy cycle. `busy` falls at the following edge.
- R5: A request with `op_mode` other than 00 is ignored, and `busy` stays 0.
- R6: A request made while `busy` is 1 is ignored, and the running pattern continues unchanged.
- R7: While the current word has bit 1 set, an advance edge is frozen if `wait_in` was high two edges earlier. The outputs then hold the word.
- R8: A host write while `busy` is 0 stores the word. A write while `busy` is 1 is dropped, and `host_rej` is high for the next cycle.
- R9: While `busy` is 0, `cs_n` and `bs_n` are all ones and `gp` is zero.
- R10: A pattern that runs past index 63 without an end bit continues at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_kind | input | 2 | 00 read single, 01 read burst, 10 write single, 11 write burst |
| op_mode | input | 2 | Operation field; only 00 starts patterns |
| wait_in | input | 1 | Asynchronous external wait |
| host_we | input | 1 | Table write strobe |
| host_addr | input | 6 | Table write index |
| host_wdata | input | 32 | Table write data |
| host_rej | output | 1 | Pulses one cycle after a write dropped while busy |
| busy | output | 1 | A pattern is running |
| cs_n | output | 8 | Active-low chip selects |
| bs_n | output | 8 | Active-low byte selects |
| gp | output | 14 | General-purpose control lines |

## Verification
The bench aims at three kinds of error: an off-by-one in the freeze latency, an end-of-pattern that drops `busy` one cycle early or late, and a wrong start-table entry. A wrong freeze latency would release or hold the wait word one cycle off. A wrong end would cut off or extend the final word. A wrong table entry would show the wrong first word. It also writes the table while busy and then runs the affected pattern. A design that accepted that write would show the new word instead of the old one. A pattern with no end bit from 0x20 onward checks the index wrap, and a design that stopped or jumped at 63 would miss the word stored at index 0.

// File: rtl/mws_pkg.sv
// Shared widths, word layout and start-index table for the sequencer.
package mws_pkg;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = 32;
    localparam int CS_W   = 8;
    localparam int BS_W   = 8;
    localparam int CTL_W  = 2;
    localparam int GP_W   = WORD_W - CS_W - BS_W - CTL_W;

    localparam logic [1:0] OP_NORMAL = 2'b00;

    localparam logic [ADDR_W-1:0] BASE_RD_ONE  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] BASE_RD_MANY = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] BASE_WR_ONE  = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] BASE_WR_MANY = ADDR_W'(8'h20);

    typedef enum logic [1:0] {
        KIND_RD_ONE  = 2'b00,
        KIND_RD_MANY = 2'b01,
        KIND_WR_ONE  = 2'b10,
        KIND_WR_MANY = 2'b11
    } kind_e;

    typedef struct packed {
        logic [CS_W-1:0] cs;
        logic [BS_W-1:0] bs;
        logic [GP_W-1:0] gp;
        logic            wait_en;
        logic            last;
    } uword_t;

    // Map a request kind to the first table index of its pattern.
    function automatic logic [ADDR_W-1:0] start_index(input kind_e k);
        case (k)
            KIND_RD_ONE:  start_index = BASE_RD_ONE;
            KIND_RD_MANY: start_index = BASE_RD_MANY;
            KIND_WR_ONE:  start_index = BASE_WR_ONE;
            default:      start_index = BASE_WR_MANY;
        endcase
    endfunction
endpackage

// File: rtl/mws_pattern_ram.sv
// Pattern table: DEPTH words with a host write port and an asynchronous read port.
// Assumes: writes are legal only while the sequencer is idle; rejected writes
// are reported with a one-cycle pulse. The array itself is not reset.
module mws_pattern_ram
    import mws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              wr_rej
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store host words only while idle.
    always_ff @(posedge clk) begin
        if (wr_en && !busy) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Flag writes that arrive during an active pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_rej <= 1'b0;
        end else begin
            wr_rej <= wr_en && busy;
        end
    end

    // Combinational read of the addressed word.
    always_comb begin
        rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/mws_wait_sync.sv
// Multi-stage synchronizer for the asynchronous wait input.
// Assumes: STAGES >= 1; output is the last stage, cleared by reset.
module mws_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop sampling of the wait line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            // Shift the wait line through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mws_index_ctrl.sv
// Index generator and word latch. Accepts a request when idle, latches the
// start word, then steps one word per clock until an end-marked word has been
// shown. A wait-enabled word holds while the synchronized wait is high.
// Assumes: rd_word is the table word at rd_addr in the same cycle.
module mws_index_ctrl
    import mws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        op_mode,
    input  logic              wait_s,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output uword_t            cur
);
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] first_idx;
    logic              accept;
    logic              frozen;

    // Decode the start index and the accept and freeze conditions.
    always_comb begin
        first_idx = start_index(kind_e'(req_kind));
        accept    = !busy && req_valid && (op_mode == OP_NORMAL);
        frozen    = busy && cur.wait_en && wait_s;
        rd_addr   = busy ? ptr : first_idx;
    end

    // Sequence state: start, advance, hold or finish a pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
            cur  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cur  <= uword_t'(rd_word);
            ptr  <= first_idx + ADDR_W'(1);
        end else if (busy && !frozen) begin
            if (cur.last) begin
                busy <= 1'b0;
                cur  <= '0;
            end else begin
                cur  <= uword_t'(rd_word);
                ptr  <= ptr + ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/mws_out_drive.sv
// Output stage: maps the latched word onto the active-low selects and the
// general-purpose lines, forcing the idle levels when no pattern runs.
// Assumes: mask bit 1 in the word means the line is asserted (driven low).
module mws_out_drive
    import mws_pkg::*;
(
    input  logic            active,
    input  uword_t          cur,
    output logic [CS_W-1:0] cs_n,
    output logic [BS_W-1:0] bs_n,
    output logic [GP_W-1:0] gp
);
    // Drive line levels from the current word or the idle defaults.
    always_comb begin
        if (active) begin
            cs_n = ~cur.cs;
            bs_n = ~cur.bs;
            gp   = cur.gp;
        end else begin
            cs_n = '1;
            bs_n = '1;
            gp   = '0;
        end
    end
endmodule

// File: rtl/mem_wave_seq.sv
// Top of the microcoded memory timing sequencer: pattern table, wait
// synchronizer, index and latch logic, and output stage.
// Assumes: wait_in is asynchronous; all other inputs are synchronous to clk.
module mem_wave_seq
    import mws_pkg::*;
#(
    parameter int WAIT_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        op_mode,
    input  logic              wait_in,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_rej,
    output logic              busy,
    output logic [CS_W-1:0]   cs_n,
    output logic [BS_W-1:0]   bs_n,
    output logic [GP_W-1:0]   gp
);
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              wait_s;
    uword_t            cur_word;
    logic              cur_wait;
    logic              cur_last;

    assign cur_wait = cur_word.wait_en;
    assign cur_last = cur_word.last;

    mws_pattern_ram u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_word),
        .wr_rej  (host_rej)
    );

    mws_wait_sync #(.STAGES(WAIT_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_in),
        .sync_out (wait_s)
    );

    mws_index_ctrl u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .op_mode   (op_mode),
        .wait_s    (wait_s),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .cur       (cur_word)
    );

    mws_out_drive u_out (
        .active (busy),
        .cur    (cur_word),
        .cs_n   (cs_n),
        .bs_n   (bs_n),
        .gp     (gp)
    );
endmodule

// File: rtl/mws_checker.sv
// Protocol checker for the sequencer, attached to the top with bind.
module mws_checker
    import mws_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      op_mode,
    input logic            host_we,
    input logic            host_rej,
    input logic            busy,
    input logic [CS_W-1:0] cs_n,
    input logic [BS_W-1:0] bs_n,
    input logic [GP_W-1:0] gp,
    input logic            wait_s,
    input logic            cur_wait,
    input logic            cur_last
);
    // R9: idle lines are deasserted.
    a_r9_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == '1) && (bs_n == '1) && (gp == '0));

    // R3: an accepted request makes the block busy.
    a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && op_mode == OP_NORMAL) |=> busy);

    // R5: other operation fields start nothing.
    a_r5_op_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && op_mode != OP_NORMAL) |=> !busy);

    // R4: an unfrozen end word is the final busy cycle.
    a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_last && !(cur_wait && wait_s)) |=> !busy);

    // R7: a frozen word keeps every line steady.
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_wait && wait_s) |=>
            busy && $stable(cs_n) && $stable(bs_n) && $stable(gp));

    // R8: a reject pulse only follows a write made while busy.
    a_r8_rej_cause: assert property (@(posedge clk) disable iff (!rst_n)
        host_rej |-> $past(host_we && busy));
endmodule

bind mem_wave_seq mws_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op_mode   (op_mode),
    .host_we   (host_we),
    .host_rej  (host_rej),
    .busy      (busy),
    .cs_n      (cs_n),
    .bs_n      (bs_n),
    .gp        (gp),
    .wait_s    (wait_s),
    .cur_wait  (cur_wait),
    .cur_last  (cur_last)
);

// File: tb/mem_wave_seq_tb.sv
module mem_wave_seq_tb;
    import mws_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [1:0]  op_mode = 2'b00;
    logic        wait_in = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rej, busy;
    logic [7:0]  cs_n, bs_n;
    logic [13:0] gp;

    mem_wave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .op_mode(op_mode), .wait_in(wait_in), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rej(host_rej),
        .busy(busy), .cs_n(cs_n), .bs_n(bs_n), .gp(gp)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Spec-level expectation state.
    logic [31:0] m_ram [64];
    logic        m_busy, m_s1, m_s2, m_rej;
    logic [31:0] m_cur;
    logic [5:0]  m_ptr;

    function automatic logic [5:0] f_start(input logic [1:0] k);
        case (k)
            2'b00:   return 6'h00;
            2'b01:   return 6'h08;
            2'b10:   return 6'h18;
            default: return 6'h20;
        endcase
    endfunction

    function automatic logic [31:0] f_word(input logic [7:0] cs, input logic [7:0] bs,
                                           input logic [13:0] g, input logic w, input logic l);
        return {cs, bs, g, w, l};
    endfunction

    function automatic logic [31:0] f_expect_lines(input logic b, input logic r, input logic [31:0] w);
        if (b) return {b, r, ~w[31:24], ~w[23:16], w[15:2]};
        return {1'b0, r, 8'hFF, 8'hFF, 14'h0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_cur <= '0; m_ptr <= '0;
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_rej <= 1'b0;
        end else begin
            m_s1  <= wait_in;
            m_s2  <= m_s1;
            m_rej <= host_we && m_busy;
            if (host_we && !m_busy) m_ram[host_addr] <= host_wdata;
            if (!m_busy && req_valid && op_mode == 2'b00) begin
                m_busy <= 1'b1;
                m_cur  <= m_ram[f_start(req_kind)];
                m_ptr  <= f_start(req_kind) + 6'd1;
            end else if (m_busy && !(m_cur[1] && m_s2)) begin
                if (m_cur[0]) begin
                    m_busy <= 1'b0; m_cur <= '0;
                end else begin
                    m_cur <= m_ram[m_ptr]; m_ptr <= m_ptr + 6'd1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Continuous comparison of every line against the expectation.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(!m_busy ? "R9 idle lines" : ((m_cur[1] && m_s2) ? "R7 frozen word" : "R3 word stream"),
                {busy, host_rej, cs_n, bs_n, gp}, f_expect_lines(m_busy, m_rej, m_cur));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic request(input logic [1:0] k, input logic [1:0] op);
        req_valid = 1'b1; req_kind = k; op_mode = op;
        tick();
        req_valid = 1'b0; op_mode = 2'b00;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            tick();
            guard++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tick(); tick();
        // R1: state during and right after reset.
        chk("R1 reset lines", {busy, host_rej, cs_n, bs_n, gp}, {1'b0, 1'b0, 8'hFF, 8'hFF, 14'h0});
        rst_n = 1'b1;
        tick();
        chk("R1 after release", {busy, host_rej, cs_n, bs_n, gp}, {1'b0, 1'b0, 8'hFF, 8'hFF, 14'h0});
        for (int i = 0; i < 64; i++) hwrite(6'(i), f_word(8'(i), 8'h00, 14'(i), 1'b0, 1'b1));
        cmp_en = 1'b1;

        // R2 and R4: each kind starts at its own index; a one-word pattern ends next edge.
        hwrite(6'h00, f_word(8'h01, 8'h10, 14'h0011, 1'b0, 1'b1));
        hwrite(6'h08, f_word(8'h02, 8'h20, 14'h0022, 1'b0, 1'b1));
        hwrite(6'h18, f_word(8'h04, 8'h40, 14'h0044, 1'b0, 1'b1));
        hwrite(6'h20, f_word(8'h08, 8'h80, 14'h0088, 1'b0, 1'b1));
        for (int k = 0; k < 4; k++) begin
            request(2'(k), 2'b00);
            chk("R2 start word cs_n", {24'h0, cs_n}, {24'h0, ~(8'h01 << k)});
            tick();
            chk("R4 busy falls after end word", {31'h0, busy}, 32'h0);
        end

        // R5: non-normal operation fields are ignored.
        for (int op = 1; op < 4; op++) begin
            request(2'b01, 2'(op));
            chk("R5 op field ignored", {31'h0, busy}, 32'h0);
        end

        // R6 and R8: a three-word burst; request and write during it.
        hwrite(6'h08, f_word(8'h11, 8'h00, 14'h1, 1'b0, 1'b0));
        hwrite(6'h09, f_word(8'h12, 8'h00, 14'h2, 1'b0, 1'b0));
        hwrite(6'h0A, f_word(8'h13, 8'h00, 14'h3, 1'b0, 1'b1));
        request(2'b01, 2'b00);
        req_valid = 1'b1; req_kind = 2'b10;
        host_we = 1'b1; host_addr = 6'h00; host_wdata = f_word(8'hEE, 8'h00, 14'h0, 1'b0, 1'b1);
        tick();
        req_valid = 1'b0; host_we = 1'b0;
        chk("R6 burst continues", {24'h0, cs_n}, {24'h0, ~8'h12});
        chk("R8 reject pulse", {31'h0, host_rej}, 32'h1);
        tick();
        chk("R6 burst third word", {24'h0, cs_n}, {24'h0, ~8'h13});
        wait_idle();
        request(2'b00, 2'b00);
        chk("R8 rejected word not stored", {24'h0, cs_n}, {24'h0, ~8'h01});
        wait_idle();

        // R7: freeze latency through the synchronizer.
        hwrite(6'h00, f_word(8'h0F, 8'h00, 14'h5, 1'b1, 1'b0));
        hwrite(6'h01, f_word(8'hF0, 8'h00, 14'h6, 1'b0, 1'b1));
        wait_in = 1'b1;
        tick(); tick();
        request(2'b00, 2'b00);
        for (int i = 0; i < 3; i++) begin
            chk("R7 held while wait", {24'h0, cs_n}, {24'h0, ~8'h0F});
            tick();
        end
        wait_in = 1'b0;
        tick(); tick();
        chk("R7 still held two edges after release", {24'h0, cs_n}, {24'h0, ~8'h0F});
        tick();
        chk("R7 advances after release", {24'h0, cs_n}, {24'h0, ~8'hF0});
        wait_idle();

        // R10: index wraps from 63 to 0.
        for (int i = 32; i < 64; i++) hwrite(6'(i), f_word(8'(i), 8'h00, 14'h0, 1'b0, 1'b0));
        hwrite(6'h00, f_word(8'hAA, 8'h00, 14'h0, 1'b0, 1'b1));
        request(2'b11, 2'b00);
        repeat (32) tick();
        chk("R10 wrap to index 0", {24'h0, cs_n}, {24'h0, ~8'hAA});
        tick();
        chk("R10 ends after wrapped word", {31'h0, busy}, 32'h0);

        // Random phase: random table, requests, wait and host writes.
        for (int i = 0; i < 64; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[0] = ($urandom % 4) == 0;
            w[1] = ($urandom % 4) == 0;
            hwrite(6'(i), w);
        end
        for (int n = 0; n < 3000; n++) begin
            wait_in   = ($urandom % 4) == 0;
            req_valid = ($urandom % 3) == 0;
            req_kind  = 2'($urandom);
            op_mode   = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            host_we   = ($urandom % 10) == 0;
            host_addr = 6'($urandom);
            host_wdata = $urandom;
            tick();
        end
        req_valid = 1'b0; host_we = 1'b0; wait_in = 1'b0;
        wait_idle();
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule